// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a clocked host and an asynchronous static RAM of 131,072 bytes (17-bit address, 8-bit data, one shared bidirectional data bus, active-low chip, output and write enables). The host issues one read or one write at a time with a request pulse. The sequencer then produces the address and the three strobes, switches its own bus driver on and off, captures read data, and ends every operation with a one-cycle done pulse.

Every timing interval (address setup, write pulse before data, data setup, write recovery, read access) is a parameter counted in clock cycles, with a minimum of one cycle. The order of the edges keeps the shared bus free of two drivers. Output enable stays high for the whole write. Chip enable falls before write enable, so the memory never drives the bus during a write. The sequencer drives the bus only after write enable is already low, and it releases the bus on the same edge that write enable rises.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After synchronous reset, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, host_busy is 0 and host_done is 0.
- R2: A request is accepted only on an edge where the block is idle. A request raised while busy is ignored: neither the address nor the memory contents change because of it. A request held high is accepted on the first idle edge, which is the edge after the done pulse.
- R3: Write (host_wr=1): on the accepting edge, mem_addr takes host_addr and mem_ce_n falls. mem_we_n falls SETUP cycles later and stays low for PULSE+DSETUP cycles. mem_addr stays unchanged while mem_ce_n is low.
- R4: mem_dq_oe rises PULSE cycles after mem_we_n falls and is high for DSETUP cycles, carrying the write byte. It falls on the same edge where mem_we_n rises, and it is never high while mem_we_n is high.
- R5: mem_oe_n stays 1 for the whole write. mem_we_n and mem_oe_n are never low together, and the controller and the memory never drive the bus in the same cycle.
- R6: After mem_we_n rises, mem_ce_n and mem_addr are held for RECOV cycles. On the next edge mem_ce_n rises and host_done is 1 for one cycle.
- R7: Read (host_wr=0): mem_ce_n falls on the accepting edge. mem_oe_n falls SETUP cycles later and stays low for ACCESS cycles. mem_we_n stays 1 and mem_dq_oe stays 0.
- R8: On the edge that ends the ACCESS interval, host_rdata takes the bus byte, host_done is 1 for one cycle, and mem_ce_n and mem_oe_n return to 1.
- R9: host_busy is 1 from the accepting edge until the done edge. It is 0 in the cycle where host_done is 1.
- R10: A written byte reads back unchanged at the lowest address (0x00000) and at the highest address (0x1FFFF), and with several data patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Operation request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_busy | output | 1 | Operation in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Captured read byte |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_oe | output | 1 | Drive enable for the shared data bus |
| mem_dq_out | output | 8 | Byte driven onto the bus |
| mem_dq_in | input | 8 | Resolved value of the data bus |

## Verification
Every result is registered, so it is due a whole number of cycles after the accepting edge. Call that edge cycle 0. A write shows chip enable at cycle 0, write enable low from SETUP, the bus driver from SETUP+PULSE, the write-enable rise at SETUP+PULSE+DSETUP, and done at SETUP+PULSE+DSETUP+RECOV. A read shows output enable from SETUP and data plus done at SETUP+ACCESS. The bench drives a request between edges and then samples every strobe 5 ns after each following rising edge, comparing it with a per-cycle expectation derived from these counts. A behavioural memory model checks contention and commits a write only when write enable rises.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSET,
    PH_WLOW,
    PH_WDRV,
    PH_WREC,
    PH_RSET,
    PH_RACC
  } phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len_m1,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= len_m1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 2,
  parameter int T_DSETUP = 1,
  parameter int T_RECOV  = 1,
  parameter int T_ACCESS = 2,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic          tmr_last,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_len_m1,
  output logic          accept,
  output logic          capture,
  output logic          busy,
  output logic          done,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe
);

  phase_e phase, nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (host_req) nxt = host_wr ? PH_WSET : PH_RSET;
      PH_WSET: if (tmr_last) nxt = PH_WLOW;
      PH_WLOW: if (tmr_last) nxt = PH_WDRV;
      PH_WDRV: if (tmr_last) nxt = PH_WREC;
      PH_WREC: if (tmr_last) nxt = PH_IDLE;
      PH_RSET: if (tmr_last) nxt = PH_RACC;
      PH_RACC: if (tmr_last) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      PH_WSET, PH_RSET: tmr_len_m1 = CW'(T_SETUP - 1);
      PH_WLOW:          tmr_len_m1 = CW'(T_PULSE - 1);
      PH_WDRV:          tmr_len_m1 = CW'(T_DSETUP - 1);
      PH_WREC:          tmr_len_m1 = CW'(T_RECOV - 1);
      PH_RACC:          tmr_len_m1 = CW'(T_ACCESS - 1);
      default:          tmr_len_m1 = '0;
    endcase
  end

  assign tmr_load = (nxt != phase);
  assign accept   = (phase == PH_IDLE) && host_req;
  assign capture  = (phase == PH_RACC) && tmr_last;
  assign busy     = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      phase <= nxt;
      ce_n  <= (nxt == PH_IDLE);
      oe_n  <= (nxt != PH_RACC);
      we_n  <= !((nxt == PH_WLOW) || (nxt == PH_WDRV));
      dq_oe <= (nxt == PH_WDRV);
      done  <= (phase != PH_IDLE) && (nxt == PH_IDLE);
    end
  end

  a_r5_we_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);
  a_r4_drive_needs_we_low: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!we_n && !ce_n));
  a_r4_drive_after_we_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> !$past(we_n));
  a_r4_release_with_we_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> !dq_oe);
  a_r3_ce_leads_we: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> !$past(ce_n));
  a_r6_ce_held_in_recovery: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> !ce_n);
  a_r7_read_quiet_write_side: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n && !dq_oe));
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: rtl/sram_host_latch.sv
module sram_host_latch #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] host_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      host_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= host_addr;
        mem_dq_out <= host_wdata;
      end
      if (capture) host_rdata <= bus_in;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 2,
  parameter int T_DSETUP = 1,
  parameter int T_RECOV  = 1,
  parameter int T_ACCESS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_busy,
  output logic          host_done,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_dq_oe,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int T_MAX = max_of(max_of(max_of(T_SETUP, T_PULSE), max_of(T_DSETUP, T_RECOV)), T_ACCESS);
  localparam int CW    = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  logic          tmr_load, tmr_last, accept, capture;
  logic [CW-1:0] tmr_len_m1;

  sram_phase_timer #(.CW(CW)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .len_m1 (tmr_len_m1),
    .last   (tmr_last)
  );

  sram_seq_fsm #(
    .T_SETUP (T_SETUP),
    .T_PULSE (T_PULSE),
    .T_DSETUP(T_DSETUP),
    .T_RECOV (T_RECOV),
    .T_ACCESS(T_ACCESS),
    .CW      (CW)
  ) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .host_req  (host_req),
    .host_wr   (host_wr),
    .tmr_last  (tmr_last),
    .tmr_load  (tmr_load),
    .tmr_len_m1(tmr_len_m1),
    .accept    (accept),
    .capture   (capture),
    .busy      (host_busy),
    .done      (host_done),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_host_latch #(.AW(AW), .DW(DW)) i_latch (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .bus_in    (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .host_rdata(host_rdata)
  );

  // R3 / R6: the address may only move while chip enable is high
  a_r3_addr_held_under_ce: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  // R2: no new operation can load while the block is busy
  a_r2_addr_still_when_busy: assert property (@(posedge clk) disable iff (rst)
    ($past(host_busy) && host_busy) |-> $stable(mem_addr));

endmodule

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;

  localparam int S  = 2;
  localparam int P  = 2;
  localparam int D  = 2;
  localparam int RC = 2;
  localparam int A  = 3;
  localparam int WT = S + P + D + RC;
  localparam int RT = S + A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [16:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_busy, host_done;
  logic [7:0]  host_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  dq_bus;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural memory
  logic [7:0]  mem_model [int unsigned];
  logic        q_en = 1'b0;
  logic [7:0]  q_data = '0;
  logic        prev_we_n = 1'b1;
  logic [7:0]  pend_d = '0;
  logic [16:0] pend_a = '0;

  assign dq_bus = mem_dq_oe ? mem_dq_out : (q_en ? q_data : 8'hzz);

  always #10 clk = ~clk;

  sram_seq_ctrl #(
    .T_SETUP(S), .T_PULSE(P), .T_DSETUP(D), .T_RECOV(RC), .T_ACCESS(A)
  ) i_sram_seq_ctrl (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
    .mem_dq_in(dq_bus)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model and bus monitor, sampled 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (!rst && !finished) begin
      chk(!(mem_dq_oe && q_en), "R5 bus contention", {30'd0, mem_dq_oe, q_en}, 32'd0);
      chk(!(!mem_we_n && !mem_oe_n), "R5 we and oe low together",
          {30'd0, mem_we_n, mem_oe_n}, 32'd3);
      chk(!(mem_dq_oe && mem_we_n), "R4 driver on with we high", {31'd0, mem_we_n}, 32'd0);
      if (!mem_ce_n && !mem_we_n) begin
        pend_d = dq_bus;
        pend_a = mem_addr;
      end
      if (!prev_we_n && mem_we_n) mem_model[32'(pend_a)] = pend_d;
      prev_we_n = mem_we_n;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        q_en   = 1'b1;
        q_data = mem_model.exists(32'(mem_addr)) ? mem_model[32'(mem_addr)] : 8'hxx;
      end else begin
        q_en = 1'b0;
      end
    end
  end

  task automatic sample();
    @(posedge clk);
    #5;
  endtask

  task automatic t_reset_state();
    sample();
    chk(mem_ce_n == 1'b1, "R1 ce_n after reset", {31'd0, mem_ce_n}, 32'd1);
    chk(mem_oe_n == 1'b1, "R1 oe_n after reset", {31'd0, mem_oe_n}, 32'd1);
    chk(mem_we_n == 1'b1, "R1 we_n after reset", {31'd0, mem_we_n}, 32'd1);
    chk(mem_dq_oe == 1'b0, "R1 dq_oe after reset", {31'd0, mem_dq_oe}, 32'd0);
    chk(host_busy == 1'b0 && host_done == 1'b0, "R1 busy/done after reset",
        {30'd0, host_busy, host_done}, 32'd0);
  endtask

  // full write with per-cycle strobe checks; R3 R4 R5 R6 R9
  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    for (int k = 0; k <= WT; k++) begin
      sample();
      if (k == 0) host_req = 1'b0;
      chk(mem_ce_n == (k >= WT), "R3 R6 ce_n in write", {31'd0, mem_ce_n}, {31'd0, k >= WT});
      chk(mem_we_n == !(k >= S && k < S + P + D), "R3 we_n timing",
          {31'd0, mem_we_n}, {31'd0, !(k >= S && k < S + P + D)});
      chk(mem_dq_oe == (k >= S + P && k < S + P + D), "R4 dq_oe timing",
          {31'd0, mem_dq_oe}, {31'd0, (k >= S + P && k < S + P + D)});
      chk(mem_oe_n == 1'b1, "R5 oe_n high in write", {31'd0, mem_oe_n}, 32'd1);
      chk(host_done == (k == WT), "R6 done pulse", {31'd0, host_done}, {31'd0, k == WT});
      chk(host_busy == (k < WT), "R9 busy in write", {31'd0, host_busy}, {31'd0, k < WT});
      if (k < WT) chk(mem_addr == a, "R3 address held", 32'(mem_addr), 32'(a));
      if (mem_dq_oe) chk(mem_dq_out == d, "R4 write byte", 32'(mem_dq_out), 32'(d));
    end
    chk(mem_model.exists(32'(a)) && mem_model[32'(a)] == d, "R10 byte stored",
        mem_model.exists(32'(a)) ? 32'(mem_model[32'(a)]) : 32'hffff_ffff, 32'(d));
  endtask

  // full read with per-cycle checks; R7 R8 R9 R10
  task automatic t_read(input logic [16:0] a, input logic [7:0] exp);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = a;
    for (int k = 0; k <= RT; k++) begin
      sample();
      if (k == 0) host_req = 1'b0;
      chk(mem_ce_n == (k >= RT), "R7 R8 ce_n in read", {31'd0, mem_ce_n}, {31'd0, k >= RT});
      chk(mem_oe_n == !(k >= S && k < RT), "R7 oe_n timing",
          {31'd0, mem_oe_n}, {31'd0, !(k >= S && k < RT)});
      chk(mem_we_n == 1'b1 && mem_dq_oe == 1'b0, "R7 write side quiet",
          {30'd0, mem_we_n, mem_dq_oe}, 32'd2);
      chk(host_done == (k == RT), "R8 done pulse", {31'd0, host_done}, {31'd0, k == RT});
      chk(host_busy == (k < RT), "R9 busy in read", {31'd0, host_busy}, {31'd0, k < RT});
      if (k == RT) chk(host_rdata == exp, "R8 R10 read data", 32'(host_rdata), 32'(exp));
    end
  endtask

  task automatic wait_done();
    for (int k = 0; k < 64; k++) begin
      sample();
      if (host_done) break;
    end
  endtask

  // R2: request while busy is ignored
  task automatic t_ignore_busy();
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h00400; host_wdata = 8'h3c;
    sample();
    host_req = 1'b0;
    sample();
    host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h00010; host_wdata = 8'h99;
    sample();
    host_req = 1'b0;
    chk(mem_addr == 17'h00400, "R2 address kept while busy", 32'(mem_addr), 32'h400);
    wait_done();
    for (int k = 0; k < 3; k++) begin
      sample();
      chk(mem_ce_n == 1'b1 && host_busy == 1'b0, "R2 no late start",
          {30'd0, mem_ce_n, host_busy}, 32'd2);
    end
    t_read(17'h00010, 8'h11);
  endtask

  // R2: held request starts on the edge after done
  task automatic t_back_to_back();
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = 17'h1ffff;
    for (int k = 0; k <= RT + 1; k++) begin
      sample();
      if (k == RT) chk(host_done == 1'b1 && mem_ce_n == 1'b1, "R2 first done",
                       {30'd0, host_done, mem_ce_n}, 32'd3);
      if (k == RT + 1) begin
        chk(mem_ce_n == 1'b0 && host_busy == 1'b1, "R2 second accepted at once",
            {30'd0, mem_ce_n, host_busy}, 32'd1);
        host_req = 1'b0;
      end
    end
    wait_done();
    chk(host_rdata == 8'h5a, "R2 second read data", 32'(host_rdata), 32'h5a);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_write(17'h00000, 8'h00);
    t_write(17'h1ffff, 8'h5a);
    t_write(17'h00010, 8'h11);
    t_write(17'h0abcd, 8'hff);
    t_write(17'h15555, 8'ha5);
    t_read(17'h00000, 8'h00);
    t_read(17'h1ffff, 8'h5a);
    t_read(17'h0abcd, 8'hff);
    t_read(17'h15555, 8'ha5);
    t_ignore_busy();
    t_read(17'h00400, 8'h3c);
    t_back_to_back();
    t_write(17'h1ffff, 8'hc3);
    t_read(17'h1ffff, 8'hc3);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule